// File: doc/BRIEF.md
# Waveform Timer Channel

A single timer channel that counts ticks from one of several clock sources and drives two waveform outputs, `wave_a` and `wave_b`. The counter can run upward freely or bounce between zero and a top value. An automatic reset on the third compare register can be added to either motion. Three compare registers (A, B and C) raise events as the count passes them. Each output has its own table of actions for its compare events and for the software restart. Each action sets, clears or toggles the output.

Software drives the channel through a small word-addressed register port. Through it, software issues commands, programs the mode word and the three compare values, reads the live count and reads the sticky event flags, which clear on read. The port also sets and clears an interrupt mask. The `irq` output is high while any unmasked event flag is set.

Top module: `tmr_wave_chan`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the direction is upward, both outputs are low, the clock enable is off, and the mode, compare values, event flags and mask are all 0.
- R2: A write to offset 0x00 is a command. Bit 0 turns the counter clock on and bit 1 turns it off; when both are set, off wins. Bit 2 is a restart: the count becomes 0, the direction becomes upward and any stop is cleared, whether or not the clock is on.
- R3: Mode bits 2:0 pick the tick source. Values 0 to 4 pick the pulse input `int_tick[n]`. Values 5 to 7 pick rising edges of `ext_clk[n-5]`. The count moves only on a tick, and only while the clock is on, mode bit 15 is set and no stop is pending.
- R4: With mode bits 14:13 = 00, the count rises by one on each tick. On a step from 0xFFFF to 0 it sets the overflow flag (status bit 0).
- R5: With bits 14:13 = 10, a tick taken while the count equals C returns the count to 0 and sets no overflow flag.
- R6: With bits 14:13 = 01 or 11, the count turns downward on a tick taken at the top value and turns upward on a tick taken at 0. The top value is 0xFFFF for 01 and C for 11. These modes never set the overflow flag. C must be at least 1.
- R7: A tick taken while the count equals A, B or C sets status bit 2, 3 or 4 respectively.
- R8: Each output action field uses 0 = none, 1 = set, 2 = clear and 3 = toggle. For `wave_a`, the A-compare field is at mode bits 17:16, the C-compare field at 19:18 and the restart field at 23:22. For `wave_b`, the B-compare field is at 25:24, the C-compare field at 27:26 and the restart field at 31:30.
- R9: When several events reach one output in the same cycle, the restart acts first, then C-compare, then A or B compare. Only events whose field is not none take part.
- R10: Mode bit 6 halts counting after a C-compare event until the next restart. Mode bit 7 turns the clock off after a C-compare event until the next on command. An on or off command in the same cycle overrides bit 7.
- R11: A read of offset 0x20 returns the event flags in bits 0, 2, 3 and 4, the clock enable in bit 16, and the live `wave_a` and `wave_b` levels in bits 17 and 18. The read clears the flags. An event in the same cycle as the read stays set.
- R12: A write to 0x24 sets mask bits and a write to 0x28 clears them, one bit per written 1. Only bits 0, 2, 3 and 4 exist. The mask reads back at 0x2C. `irq` is the OR of the flags ANDed with the mask.
- R13: Offsets 0x04, 0x10, 0x14, 0x18 and 0x1C read back the mode, count, A, B and C. The count cannot be written, and offset 0x00 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at 0x20) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| int_tick | input | N_INT (5) | Prescaled tick pulses, one cycle each |
| ext_clk | input | N_EXT (3) | External clock levels, counted on rising edges |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong direction bit becomes visible on the waveform outputs at the next compare event, and shows up at once on a read of offset 0x10. A compare event that is missed or arrives early changes `wave_a`, `wave_b` or `irq` in the same cycle as the tick. A mistake in the action priority shows up when the restart coincides with a compare: the output then lands at the wrong level for the rest of the run. An error in the stop or clock-off state freezes the count or keeps it moving, and status bit 16 reports the clock enable directly.

// File: rtl/tmr_wave_pkg.sv
// Shared constants and types for the waveform timer channel.
// Assumes byte offsets on an 8-bit address and 32-bit register words.
package tmr_wave_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CMPA = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CMPB = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CMPC = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MSET = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MCLR = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h2C;

    // Event flag bits that exist (bit 1 is reserved).
    localparam logic [4:0] EVT_VALID = 5'b11101;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    // Applies one output action to the current level.
    function automatic logic act_apply(input logic cur, input act_e a);
        case (a)
            ACT_SET: return 1'b1;
            ACT_CLR: return 1'b0;
            ACT_TGL: return ~cur;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_tick_sel.sv
// Tick source selector: picks one internal pulse or the rising edge of one
// external clock level. Assumes external levels are already synchronous.
module tmr_tick_sel #(
    parameter int N_INT = 5,
    parameter int N_EXT = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_INT-1:0]                 int_tick,
    input  logic [N_EXT-1:0]                 ext_clk,
    input  logic [$clog2(N_INT+N_EXT)-1:0]   sel,
    output logic                             tick
);
    localparam int N_SRC = N_INT + N_EXT;

    logic [N_EXT-1:0] ext_q;
    logic [N_EXT-1:0] ext_rise;
    logic [N_SRC-1:0] src;

    // Remember the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= ext_clk;
    end

    generate
        for (genvar g = 0; g < N_EXT; g++) begin : g_edge
            assign ext_rise[g] = ext_clk[g] & ~ext_q[g];
        end
    endgenerate

    assign src  = {ext_rise, int_tick};
    assign tick = src[sel];
endmodule

// File: rtl/tmr_count.sv
// Counter core: up or up/down motion with optional auto-reset at compare C,
// plus compare and overflow events. Assumes C >= 1 in up/down modes.
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic             updown,
    input  logic             auto_rc,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_ev,
    output logic             a_ev,
    output logic             b_ev,
    output logic             c_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             step;
    logic             dir_up;
    logic             nxt_dir;
    logic             wrap;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] nxt;

    assign step = tick & run;
    assign top  = auto_rc ? cmp_c : CNT_MAX;

    // Next count and direction for one tick.
    always_comb begin
        nxt     = cnt + 1'b1;
        nxt_dir = dir_up;
        wrap    = 1'b0;
        if (!updown) begin
            if (auto_rc && cnt == cmp_c) nxt  = '0;
            else                         wrap = (cnt == CNT_MAX);
        end else if (dir_up) begin
            if (cnt == top) begin
                nxt     = cnt - 1'b1;
                nxt_dir = 1'b0;
            end
        end else if (cnt == '0) begin
            nxt_dir = 1'b1;
        end else begin
            nxt = cnt - 1'b1;
        end
    end

    // Count register; a restart overrides any tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (step) begin
            cnt    <= nxt;
            dir_up <= nxt_dir;
        end
    end

    assign ovf_ev = step & wrap & ~restart;
    assign a_ev   = step & (cnt == cmp_a);
    assign b_ev   = step & (cnt == cmp_b);
    assign c_ev   = step & (cnt == cmp_c);
endmodule

// File: rtl/tmr_wave_out.sv
// One waveform output: applies the action of the highest-priority event
// (restart, then compare C, then own compare) whose action is not none.
module tmr_wave_out
    import tmr_wave_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_cmp,
    input  logic ev_c,
    input  logic ev_sw,
    input  act_e act_cmp,
    input  act_e act_c,
    input  act_e act_sw,
    output logic level
);
    act_e act;

    // Pick the winning action for this cycle.
    always_comb begin
        if (ev_sw && act_sw != ACT_NONE)        act = act_sw;
        else if (ev_c && act_c != ACT_NONE)     act = act_c;
        else if (ev_cmp && act_cmp != ACT_NONE) act = act_cmp;
        else                                    act = ACT_NONE;
    end

    // Output level register.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= 1'b0;
        else        level <= act_apply(level, act);
    end
endmodule

// File: rtl/tmr_wave_chan.sv
// Waveform timer channel top: register port, clock enable and stop state,
// event flags with read-clear, interrupt mask, and two waveform outputs.
// Assumes one register access per cycle and CNT_W <= 32.
module tmr_wave_chan
    import tmr_wave_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_INT = 5,
    parameter int N_EXT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [N_INT-1:0]  int_tick,
    input  logic [N_EXT-1:0]  ext_clk,
    output logic              wave_a,
    output logic              wave_b,
    output logic              irq
);
    localparam int SEL_W = $clog2(N_INT + N_EXT);

    logic [DATA_W-1:0] mode;
    logic [CNT_W-1:0]  cmp_a, cmp_b, cmp_c, cnt;
    logic              clk_en, stopped, run, tick, swtrig, wr_cmd;
    logic              ovf_ev, a_ev, b_ev, c_ev;
    logic [4:0]        flags, mask, new_ev;
    logic [1:0]        ev_own, lvl;
    act_e              act_own [2];
    act_e              act_c   [2];
    act_e              act_sw  [2];

    assign wr_cmd = wr_en && addr == OFS_CMD;
    assign swtrig = wr_cmd & wdata[2];
    assign run    = clk_en & ~stopped & mode[15];

    tmr_tick_sel #(.N_INT(N_INT), .N_EXT(N_EXT)) u_sel (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_clk(ext_clk),
        .sel(mode[SEL_W-1:0]), .tick(tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .restart(swtrig),
        .updown(mode[13]), .auto_rc(mode[14]),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cnt(cnt),
        .ovf_ev(ovf_ev), .a_ev(a_ev), .b_ev(b_ev), .c_ev(c_ev)
    );

    assign ev_own     = {b_ev, a_ev};
    assign act_own[0] = act_e'(mode[17:16]);
    assign act_c[0]   = act_e'(mode[19:18]);
    assign act_sw[0]  = act_e'(mode[23:22]);
    assign act_own[1] = act_e'(mode[25:24]);
    assign act_c[1]   = act_e'(mode[27:26]);
    assign act_sw[1]  = act_e'(mode[31:30]);

    generate
        for (genvar g = 0; g < 2; g++) begin : g_out
            tmr_wave_out u_out (
                .clk(clk), .rst_n(rst_n), .ev_cmp(ev_own[g]), .ev_c(c_ev),
                .ev_sw(swtrig), .act_cmp(act_own[g]), .act_c(act_c[g]),
                .act_sw(act_sw[g]), .level(lvl[g])
            );
        end
    endgenerate

    assign wave_a = lvl[0];
    assign wave_b = lvl[1];

    // Clock enable and stop state, commands overriding compare-C effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en  <= 1'b0;
            stopped <= 1'b0;
        end else begin
            if (wr_cmd && wdata[1])      clk_en <= 1'b0;
            else if (wr_cmd && wdata[0]) clk_en <= 1'b1;
            else if (c_ev && mode[7])    clk_en <= 1'b0;
            if (swtrig)                  stopped <= 1'b0;
            else if (c_ev && mode[6])    stopped <= 1'b1;
        end
    end

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
            cmp_c <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MODE: mode  <= wdata;
                OFS_CMPA: cmp_a <= wdata[CNT_W-1:0];
                OFS_CMPB: cmp_b <= wdata[CNT_W-1:0];
                OFS_CMPC: cmp_c <= wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    assign new_ev = {c_ev, b_ev, a_ev, 1'b0, ovf_ev};

    // Sticky event flags with clear-on-read, and the interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            if (rd_en && addr == OFS_STAT) flags <= new_ev;
            else                           flags <= flags | new_ev;
            if (wr_en && addr == OFS_MSET) mask <= mask | (wdata[4:0] & EVT_VALID);
            if (wr_en && addr == OFS_MCLR) mask <= mask & ~wdata[4:0];
        end
    end

    assign irq = |(flags & mask);

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_MODE: rdata = mode;
                OFS_CNT:  rdata = DATA_W'(cnt);
                OFS_CMPA: rdata = DATA_W'(cmp_a);
                OFS_CMPB: rdata = DATA_W'(cmp_b);
                OFS_CMPC: rdata = DATA_W'(cmp_c);
                OFS_STAT: rdata = {13'b0, wave_b, wave_a, clk_en, 11'b0, flags};
                OFS_MASK: rdata = DATA_W'(mask);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_wave_chan_chk.sv
// Property checker for the waveform timer channel, bound to every instance.
module tmr_wave_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      mode,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             tick,
    input logic             clk_en,
    input logic             irq
);
    logic cmd_w;
    assign cmd_w = wr_en && addr == 8'h00;

    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[2]) |=> cnt == '0);

    assert_off_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[1]) |=> !clk_en);

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !(cmd_w && wdata[2])) |=> $stable(cnt));

    assert_bounce_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && mode[13] && !(cmd_w && wdata[2]))
        |=> (cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    assert_mask_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h28 && wdata[4:0] == 5'h1F) |=> !irq);
endmodule

bind tmr_wave_chan tmr_wave_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode(mode), .cnt(cnt), .run(run), .tick(tick), .clk_en(clk_en), .irq(irq)
);

// File: tb/tmr_wave_chan_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped on each rising edge and compared
// on each falling edge; register reads compared against the model.
module tmr_wave_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  int_tick = '0;
    logic [2:0]  ext_clk = '0;
    logic        wave_a, wave_b, irq;

    int checks = 0, errs = 0, tick_pat = 0;

    // Model state.
    int         m_cnt;
    bit         m_up, m_en, m_stop, m_a, m_b;
    bit [31:0]  m_mode;
    int         m_ra, m_rb, m_rc;
    bit [4:0]   m_flags, m_mask;
    bit [2:0]   m_extq;

    tmr_wave_chan uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .int_tick(int_tick), .ext_clk(ext_clk),
        .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit wave_next(bit cur, bit e0, bit [1:0] c0, bit e1, bit [1:0] c1,
                                     bit e2, bit [1:0] c2);
        bit [1:0] c;
        c = 2'd0;
        if (e0 && c0 != 0)      c = c0;
        else if (e1 && c1 != 0) c = c1;
        else if (e2 && c2 != 0) c = c2;
        case (c)
            2'd1:    return 1'b1;
            2'd2:    return 1'b0;
            2'd3:    return !cur;
            default: return cur;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a)
            8'h04:   return m_mode;
            8'h10:   return 32'(m_cnt);
            8'h14:   return 32'(m_ra);
            8'h18:   return 32'(m_rb);
            8'h1C:   return 32'(m_rc);
            8'h20:   return {13'b0, m_b, m_a, m_en, 11'b0, m_flags};
            8'h2C:   return {27'b0, m_mask};
            default: return 32'h0;
        endcase
    endfunction

    // Reference model step, one per rising edge.
    always @(posedge clk) begin
        bit [2:0] sel;
        bit tick, sw, run, ea, eb, ec, ov, cw;
        int top;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_en = 0; m_stop = 0; m_a = 0; m_b = 0;
            m_mode = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_flags = 0; m_mask = 0; m_extq = 0;
        end else begin
            sel  = m_mode[2:0];
            tick = (sel < 5) ? int_tick[sel] : (ext_clk[sel-5] && !m_extq[sel-5]);
            m_extq = ext_clk;
            cw   = wr_en && addr == 8'h00;
            sw   = cw && wdata[2];
            run  = m_en && !m_stop && m_mode[15];
            ea = run && tick && m_cnt == m_ra;
            eb = run && tick && m_cnt == m_rb;
            ec = run && tick && m_cnt == m_rc;
            ov = 0;
            if (sw) begin
                m_cnt = 0; m_up = 1;
            end else if (run && tick) begin
                top = m_mode[14] ? m_rc : 65535;
                if (!m_mode[13]) begin
                    if (m_mode[14] && m_cnt == m_rc) m_cnt = 0;
                    else begin
                        ov = (m_cnt == 65535);
                        m_cnt = (m_cnt + 1) % 65536;
                    end
                end else if (m_up) begin
                    if (m_cnt == top) begin m_up = 0; m_cnt = m_cnt - 1; end
                    else m_cnt = (m_cnt + 1) % 65536;
                end else begin
                    if (m_cnt == 0) begin m_up = 1; m_cnt = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end
            m_a = wave_next(m_a, sw, m_mode[23:22], ec, m_mode[19:18], ea, m_mode[17:16]);
            m_b = wave_next(m_b, sw, m_mode[31:30], ec, m_mode[27:26], eb, m_mode[25:24]);
            if (cw && wdata[1])          m_en = 0;
            else if (cw && wdata[0])     m_en = 1;
            else if (ec && m_mode[7])    m_en = 0;
            if (sw)                      m_stop = 0;
            else if (ec && m_mode[6])    m_stop = 1;
            if (rd_en && addr == 8'h20) m_flags = {ec, eb, ea, 1'b0, ov};
            else                        m_flags = m_flags | {ec, eb, ea, 1'b0, ov};
            if (wr_en) begin
                case (addr)
                    8'h04: m_mode = wdata;
                    8'h14: m_ra = int'(wdata[15:0]);
                    8'h18: m_rb = int'(wdata[15:0]);
                    8'h1C: m_rc = int'(wdata[15:0]);
                    8'h24: m_mask = m_mask | (wdata[4:0] & 5'b11101);
                    8'h28: m_mask = m_mask & ~wdata[4:0];
                    default: ;
                endcase
            end
        end
    end

    // Output comparison on every falling edge (R8 outputs, R12 interrupt).
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 wave_a", wave_a, m_a);
            chk("R8 wave_b", wave_b, m_b);
            chk("R12 irq", irq, m_mask & m_flags ? 1 : 0);
        end
    end

    // Tick stimulus patterns.
    always @(negedge clk) begin
        case (tick_pat)
            1: int_tick <= 5'($urandom);
            2: int_tick <= 5'h1F;
            3: ext_clk  <= 3'($urandom);
            default: int_tick <= '0;
        endcase
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        @(negedge clk); rd_en = 1; addr = a;
        #1 chk(req, rdata, exp_rd(a));
        @(negedge clk); rd_en = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog all actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(8'h04, "R1 mode"); rd(8'h10, "R1 count"); rd(8'h20, "R1 status");
        rd(8'h2C, "R1 mask");
        chk("R1 wave_a", wave_a, 0); chk("R1 irq", irq, 0);

        // R3 R5 R7 R8: auto-reset upward, internal source 0, random ticks
        wr(8'h14, 3); wr(8'h18, 5); wr(8'h1C, 8);
        wr(8'h04, 32'h8000 | (2 << 13) | (1 << 16) | (2 << 18) | (3 << 24));
        rd(8'h14, "R13 cmp A"); rd(8'h1C, "R13 cmp C");
        wr(8'h00, 5);
        tick_pat = 1;
        repeat (80) @(negedge clk);
        rd(8'h10, "R5 count"); rd(8'h20, "R11 status"); rd(8'h20, "R11 cleared");
        // R12: mask on compare C
        wr(8'h24, 32'h1F); rd(8'h2C, "R12 mask set");
        repeat (30) @(negedge clk);
        wr(8'h28, 32'h1F); rd(8'h2C, "R12 mask clr");

        // R6: bounce with top C, external source 0 (select 5)
        wr(8'h1C, 6);
        wr(8'h04, 32'h8005 | (3 << 13) | (3 << 18) | (1 << 24) | (2 << 26));
        wr(8'h00, 4);
        tick_pat = 3;
        repeat (100) @(negedge clk);
        rd(8'h10, "R6 count"); rd(8'h20, "R6 status");

        // R9: restart coincides with compare A; restart clears, compare sets
        tick_pat = 2;
        wr(8'h14, 1);
        wr(8'h04, 32'h8000 | (1 << 16) | (2 << 22));
        wr(8'h00, 4); wr(8'h00, 4);
        chk("R9 priority", wave_a, 0);

        // R4: upward free run to overflow
        wr(8'h04, 32'h8000);
        wr(8'h00, 4);
        repeat (65540) @(negedge clk);
        rd(8'h20, "R4 overflow");

        // R6: bounce at 0xFFFF
        wr(8'h04, 32'h8000 | (1 << 13));
        wr(8'h00, 4);
        repeat (65600) @(negedge clk);
        rd(8'h10, "R6 top turn"); rd(8'h20, "R6 no overflow");

        // R10: stop on compare C, then restart, then clock-off on compare C
        wr(8'h1C, 4);
        wr(8'h04, 32'h8040 | (2 << 13));
        wr(8'h00, 4);
        repeat (20) @(negedge clk);
        rd(8'h10, "R10 stopped count"); rd(8'h20, "R10 still on");
        wr(8'h04, 32'h8080 | (2 << 13));
        wr(8'h00, 4);
        repeat (20) @(negedge clk);
        rd(8'h20, "R10 clock off"); rd(8'h10, "R10 frozen");
        wr(8'h00, 1); rd(8'h20, "R10 clock on");

        // R2: on and off together; R13: command reads zero
        wr(8'h00, 3); rd(8'h20, "R2 off wins"); rd(8'h00, "R13 cmd reads 0");
        rd(8'h18, "R13 cmp B");
        tick_pat = 0;
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
    end
endmodule